// File: doc/BRIEF.md
# Point-to-Point Serial Command Slave

This block is the bus side of a low-power timekeeping device. It watches an oversampled two-wire serial bus (SCL and SDA, both taken in on the system clock) and acts as the only slave on a point-to-point link. Its data line is push-pull: the block reports a drive value and an output enable, and the pad releases the line whenever the enable is low. One fixed device address is accepted. With the direction bit clear, every following byte is a one-byte instruction that sets or clears a control level. The only exception is the counter-load instruction, which takes up to three parameter bytes. With the direction bit set, the block returns the three bytes of an external 24-bit counter, most significant byte first, and keeps cycling through them for as long as the master acknowledges.

Counter-load bytes leave on a small stream port: `ld_valid` with a one-hot byte-lane select and the byte. The port has no back-pressure. The sink must take every beat in the cycle it is offered, because the serial master cannot be stalled. The control levels (divider stop, sleep, clock-out, fast mode) and the access flag are plain level outputs. The access flag tells the counter owner to hold increments while a transfer is in progress.

Top module: `p2p_cmd_slave`

## Requirements
- R1: After reset, divider stop, sleep, clock-out and fast mode are all low, `sda_oe` is low, `access_active` is low and no load beat is issued.
- R2: The slave acknowledges the address byte 0xA0 (write) and 0xA1 (read), with the bus sent MSB first. Any other address gets no acknowledge and no access, and later bytes have no effect until the next START or STOP.
- R3: For every byte it receives, the slave drives SDA low with `sda_oe` high from the SCL fall after the eighth bit until the SCL fall after the ninth.
- R4: The written opcodes are 0x11 and 0x10 (divider stop on/off), 0x21 and 0x20 (sleep on/off), 0x31 and 0x30 (clock-out on/off), and 0x41 and 0x40 (fast mode on/off). Each one takes effect at the ninth SCL rise of its byte. Any other byte outside a load sequence changes no control level, and control levels change only while `access_active` is high.
- R5: Byte 0x80 opens a load. The next one, two or three bytes each issue one beat carrying the byte. `ld_sel` is one-hot: bit 2 marks counter bits 23:16, bit 1 marks 15:8 and bit 0 marks 7:0. A START or STOP part way through ends the sequence after the beats already sent. A fourth byte is decoded as a new instruction.
- R6: Any number of instructions, in any order, may follow a single write address.
- R7: On a read, the slave returns counter bits 23:16, then 15:8, then 7:0, then 23:16 again, and so on. Each byte is sent MSB first, and each byte's value is taken from `cnt_value` when that byte begins.
- R8: After the master withholds the acknowledge on a read byte, `sda_oe` stays low for the rest of the transfer.
- R9: `access_active` rises at the acknowledge clock of a matching address and falls at the next STOP or repeated START.
- R10: `sda_oe` turns on only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line, asynchronous |
| sda_i | input | 1 | Bus data line as seen at the pad, asynchronous |
| cnt_value | input | 24 | Present counter value returned on reads |
| sda_o | output | 1 | Data value driven onto SDA |
| sda_oe | output | 1 | SDA drive enable; low releases the line |
| div_stop | output | 1 | Divider held stopped and reset |
| sleep_en | output | 1 | Deep sleep requested |
| clk_out_en | output | 1 | Raw oscillator clock routed to the interrupt pin |
| fast_en | output | 1 | Fast increment mode |
| ld_valid | output | 1 | Load beat valid, no back-pressure |
| ld_sel | output | 3 | One-hot byte lane of the load beat |
| ld_data | output | 8 | Byte written to the selected lane |
| access_active | output | 1 | Transfer in progress; counter must hold increments |

## Verification
If the bit position goes wrong, the acknowledge appears in the wrong SCL period. The master then sees a missing or misplaced low on the ninth clock of the very next byte. A parameter counter that is not cleared by START or STOP shows up as a stray load beat on the first byte of the following access. A bad lane pointer first becomes visible in the second byte returned on a read. A control register that latches the wrong bit shows at its output pin a few system clocks after the ninth SCL rise of the instruction. All of these are checked at the ports within the byte where they occur or the one after it.

// File: rtl/p2p_cmd_pkg.sv
package p2p_cmd_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_WRITE,
    ST_READ,
    ST_SKIP
  } link_state_e;

  // opcode nibbles (upper half of an instruction byte)
  localparam logic [3:0] OPC_DIV    = 4'h1;
  localparam logic [3:0] OPC_SLEEP  = 4'h2;
  localparam logic [3:0] OPC_CLKOUT = 4'h3;
  localparam logic [3:0] OPC_FAST   = 4'h4;
  localparam logic [3:0] OPC_LOAD   = 4'h8;

  typedef struct packed {
    logic div_stop;
    logic sleep;
    logic clk_out;
    logic fast;
  } ctrl_t;

endpackage

// File: rtl/p2p_line_sampler.sv
module p2p_line_sampler #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic bus_start,
  output logic bus_stop
);

  logic [SYNC_STAGES-1:0] scl_pipe;
  logic [SYNC_STAGES-1:0] sda_pipe;
  logic                   scl_q;
  logic                   sda_q;

  generate
    if (SYNC_STAGES > 1) begin : g_multi
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          scl_pipe <= '1;
          sda_pipe <= '1;
        end else begin
          scl_pipe <= {scl_pipe[SYNC_STAGES-2:0], scl_i};
          sda_pipe <= {sda_pipe[SYNC_STAGES-2:0], sda_i};
        end
      end
    end else begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          scl_pipe <= '1;
          sda_pipe <= '1;
        end else begin
          scl_pipe <= scl_i;
          sda_pipe <= sda_i;
        end
      end
    end
  endgenerate

  assign scl_s = scl_pipe[SYNC_STAGES-1];
  assign sda_s = sda_pipe[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s;
      sda_q <= sda_s;
    end
  end

  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign bus_start = scl_s & scl_q & sda_q & ~sda_s;
  assign bus_stop  = scl_s & scl_q & ~sda_q & sda_s;

endmodule

// File: rtl/p2p_cmd_decode.sv
module p2p_cmd_decode
  import p2p_cmd_pkg::*;
#(
  parameter  int CNT_W = 24,
  localparam int NB    = CNT_W / 8,
  localparam int IW    = $clog2(NB + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          seq_clear,
  input  logic          byte_valid,
  input  logic [7:0]    byte_data,
  output ctrl_t         ctrl,
  output logic          ld_valid,
  output logic [NB-1:0] ld_sel,
  output logic [7:0]    ld_data
);

  logic [IW-1:0] params_left;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl        <= '0;
      params_left <= '0;
      ld_valid    <= 1'b0;
      ld_sel      <= '0;
      ld_data     <= '0;
    end else begin
      ld_valid <= 1'b0;
      if (seq_clear) begin
        params_left <= '0;
      end else if (byte_valid) begin
        if (params_left != '0) begin
          // parameter byte: lanes run from the top byte downward
          ld_valid    <= 1'b1;
          ld_sel      <= NB'(1) << (params_left - IW'(1));
          ld_data     <= byte_data;
          params_left <= params_left - IW'(1);
        end else if (byte_data == {OPC_LOAD, 4'h0}) begin
          params_left <= IW'(NB);
        end else if (byte_data[3:1] == 3'b000) begin
          case (byte_data[7:4])
            OPC_DIV:    ctrl.div_stop <= byte_data[0];
            OPC_SLEEP:  ctrl.sleep    <= byte_data[0];
            OPC_CLKOUT: ctrl.clk_out  <= byte_data[0];
            OPC_FAST:   ctrl.fast     <= byte_data[0];
            default:    ;
          endcase
        end
      end
    end
  end

endmodule

// File: rtl/p2p_cmd_slave.sv
module p2p_cmd_slave
  import p2p_cmd_pkg::*;
#(
  parameter int         SYNC_STAGES = 2,
  parameter int         CNT_W       = 24,
  parameter logic [6:0] DEV_ADDR    = 7'h50
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               scl_i,
  input  logic               sda_i,
  input  logic [CNT_W-1:0]   cnt_value,
  output logic               sda_o,
  output logic               sda_oe,
  output logic               div_stop,
  output logic               sleep_en,
  output logic               clk_out_en,
  output logic               fast_en,
  output logic               ld_valid,
  output logic [CNT_W/8-1:0] ld_sel,
  output logic [7:0]         ld_data,
  output logic               access_active
);

  localparam int NB = CNT_W / 8;
  localparam int LW = (NB > 1) ? $clog2(NB) : 1;

  logic scl_s, sda_s, scl_rise, scl_fall, bus_start, bus_stop;
  logic seq_clear;

  link_state_e state;
  logic [3:0]  bitcnt;
  logic [7:0]  shreg;
  logic [7:0]  txbyte;
  logic [LW-1:0] lane;
  logic [LW-1:0] lane_nxt;
  logic        rd_dir;
  logic        rd_more;
  logic        byte_valid;
  logic [7:0]  byte_q;
  ctrl_t       ctrl;

  logic [7:0] lane_bytes [NB];

  p2p_line_sampler #(.SYNC_STAGES(SYNC_STAGES)) u_sampler (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .scl_s     (scl_s),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .bus_start (bus_start),
    .bus_stop  (bus_stop)
  );

  assign seq_clear = bus_start | bus_stop;

  p2p_cmd_decode #(.CNT_W(CNT_W)) u_decode (
    .clk        (clk),
    .rst_n      (rst_n),
    .seq_clear  (seq_clear),
    .byte_valid (byte_valid),
    .byte_data  (byte_q),
    .ctrl       (ctrl),
    .ld_valid   (ld_valid),
    .ld_sel     (ld_sel),
    .ld_data    (ld_data)
  );

  assign div_stop   = ctrl.div_stop;
  assign sleep_en   = ctrl.sleep;
  assign clk_out_en = ctrl.clk_out;
  assign fast_en    = ctrl.fast;

  // lane 0 is the most significant byte of the counter
  generate
    for (genvar g = 0; g < NB; g++) begin : g_lane
      assign lane_bytes[g] = cnt_value[CNT_W-1-8*g -: 8];
    end
  endgenerate

  assign lane_nxt = (lane == LW'(NB - 1)) ? '0 : lane + LW'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state         <= ST_IDLE;
      bitcnt        <= '0;
      shreg         <= '0;
      txbyte        <= '0;
      lane          <= '0;
      rd_dir        <= 1'b0;
      rd_more       <= 1'b0;
      byte_valid    <= 1'b0;
      byte_q        <= '0;
      sda_o         <= 1'b1;
      sda_oe        <= 1'b0;
      access_active <= 1'b0;
    end else begin
      byte_valid <= 1'b0;
      if (bus_start || bus_stop) begin
        state         <= bus_start ? ST_ADDR : ST_IDLE;
        bitcnt        <= '0;
        sda_oe        <= 1'b0;
        sda_o         <= 1'b1;
        access_active <= 1'b0;
      end else begin
        case (state)
          ST_ADDR, ST_WRITE: begin
            if (scl_rise) begin
              if (bitcnt < 4'd8) begin
                shreg  <= {shreg[6:0], sda_s};
                bitcnt <= bitcnt + 4'd1;
                if (state == ST_ADDR && bitcnt == 4'd7) begin
                  rd_dir <= sda_s;
                  if (shreg[6:0] != DEV_ADDR) state <= ST_SKIP;
                end
              end else if (bitcnt == 4'd8) begin
                // ninth clock: the acknowledge cycle
                bitcnt <= 4'd9;
                if (state == ST_ADDR) begin
                  access_active <= 1'b1;
                end else begin
                  byte_valid <= 1'b1;
                  byte_q     <= shreg;
                end
              end
            end else if (scl_fall) begin
              if (bitcnt == 4'd8) begin
                sda_oe <= 1'b1;
                sda_o  <= 1'b0;
              end else if (bitcnt == 4'd9) begin
                bitcnt <= '0;
                if (state == ST_ADDR && rd_dir) begin
                  state  <= ST_READ;
                  lane   <= '0;
                  txbyte <= lane_bytes[0];
                  sda_oe <= 1'b1;
                  sda_o  <= lane_bytes[0][7];
                end else begin
                  state  <= ST_WRITE;
                  sda_oe <= 1'b0;
                  sda_o  <= 1'b1;
                end
              end
            end
          end

          ST_READ: begin
            if (scl_rise) begin
              if (bitcnt < 4'd8) begin
                bitcnt <= bitcnt + 4'd1;
              end else if (bitcnt == 4'd8) begin
                bitcnt  <= 4'd9;
                rd_more <= ~sda_s;
              end
            end else if (scl_fall) begin
              if (bitcnt >= 4'd1 && bitcnt <= 4'd7) begin
                sda_o <= txbyte[3'd7 - bitcnt[2:0]];
              end else if (bitcnt == 4'd8) begin
                sda_oe <= 1'b0;
                sda_o  <= 1'b1;
              end else if (bitcnt == 4'd9) begin
                bitcnt <= '0;
                if (rd_more) begin
                  lane   <= lane_nxt;
                  txbyte <= lane_bytes[lane_nxt];
                  sda_oe <= 1'b1;
                  sda_o  <= lane_bytes[lane_nxt][7];
                end else begin
                  state <= ST_SKIP;
                end
              end
            end
          end

          default: ;
        endcase
      end
    end
  end

endmodule

// File: rtl/p2p_cmd_slave_chk.sv
module p2p_cmd_slave_chk #(
  parameter int NB = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          scl_s,
  input logic          bus_stop,
  input logic          sda_o,
  input logic          sda_oe,
  input logic          access_active,
  input logic          ld_valid,
  input logic [NB-1:0] ld_sel,
  input logic [3:0]    ctrl
);

  // R3: the address acknowledge is being driven low when the access opens
  a_r3_ack_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(access_active) |-> (sda_oe && !sda_o));

  // R4: control levels move only inside an access
  a_r4_ctrl_in_access: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl != $past(ctrl)) |-> access_active);

  // R5: each load beat names exactly one lane
  a_r5_one_lane: assert property (@(posedge clk) disable iff (!rst_n)
    ld_valid |-> ($countones(ld_sel) == 1));

  // R5: load beats only inside an access
  a_r5_load_in_access: assert property (@(posedge clk) disable iff (!rst_n)
    ld_valid |-> access_active);

  // R9: STOP closes the access and frees the line
  a_r9_stop_ends: assert property (@(posedge clk) disable iff (!rst_n)
    bus_stop |=> (!access_active && !sda_oe));

  // R10: drive turns on only while the clock line is low
  a_r10_drive_on_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_s);

endmodule

bind p2p_cmd_slave p2p_cmd_slave_chk #(.NB(CNT_W / 8)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .scl_s         (scl_s),
  .bus_stop      (bus_stop),
  .sda_o         (sda_o),
  .sda_oe        (sda_oe),
  .access_active (access_active),
  .ld_valid      (ld_valid),
  .ld_sel        (ld_sel),
  .ctrl          ({div_stop, sleep_en, clk_out_en, fast_en})
);

// File: tb/test_p2p_cmd_slave.sv
`timescale 1ns/1ps
module test_p2p_cmd_slave;

  localparam int Q  = 10;
  localparam int NB = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        scl_m = 1'b1;
  logic        sda_m = 1'b1;
  logic        m_en = 1'b1;
  logic [23:0] cnt_value = '0;
  logic        sda_o, sda_oe, div_stop, sleep_en, clk_out_en, fast_en;
  logic        ld_valid, access_active;
  logic [NB-1:0] ld_sel;
  logic [7:0]  ld_data;
  wire         sda_bus;

  int n_chk = 0;
  int n_fail = 0;
  int drive_viol = 0;
  logic oe_prev = 1'b0;
  logic [NB+7:0] exp_q [$];

  always #10 clk = ~clk;

  assign sda_bus = sda_oe ? sda_o : (m_en ? sda_m : 1'b1);

  p2p_cmd_slave i_p2p_cmd_slave (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus),
    .cnt_value(cnt_value), .sda_o(sda_o), .sda_oe(sda_oe),
    .div_stop(div_stop), .sleep_en(sleep_en), .clk_out_en(clk_out_en),
    .fast_en(fast_en), .ld_valid(ld_valid), .ld_sel(ld_sel),
    .ld_data(ld_data), .access_active(access_active)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // scoreboard monitor for load beats (R5)
  always @(negedge clk) begin
    if (rst_n && ld_valid) begin
      n_chk++;
      if (exp_q.size() == 0) begin
        n_fail++;
        $display("FAIL R5: actual beat %b/%h expected none", ld_sel, ld_data);
      end else begin
        logic [NB+7:0] e;
        e = exp_q.pop_front();
        if ({ld_sel, ld_data} !== e) begin
          n_fail++;
          $display("FAIL R5: actual beat %h expected %h", {ld_sel, ld_data}, e);
        end
      end
    end
  end

  // R10 monitor: drive may only switch on while SCL is low
  always @(negedge clk) begin
    if (rst_n && sda_oe && !oe_prev && scl_m) drive_viol++;
    oe_prev <= sda_oe;
  end

  task automatic wq();
    repeat (Q) @(negedge clk);
  endtask

  task automatic m_start();
    m_en = 1'b1; sda_m = 1'b1; wq();
    scl_m = 1'b1; wq();
    sda_m = 1'b0; wq();
    scl_m = 1'b0; wq();
  endtask

  task automatic m_stop();
    m_en = 1'b1; sda_m = 1'b0; wq();
    scl_m = 1'b1; wq();
    sda_m = 1'b1; wq();
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack, output logic oe_seen);
    for (int i = 7; i >= 0; i--) begin
      m_en = 1'b1; sda_m = b[i]; wq();
      scl_m = 1'b1; wq(); wq();
      scl_m = 1'b0; wq();
    end
    m_en = 1'b0; wq();
    scl_m = 1'b1; wq();
    ack = sda_bus; oe_seen = sda_oe;
    wq();
    scl_m = 1'b0; wq();
  endtask

  task automatic recv_byte(input logic master_ack, output logic [7:0] b);
    m_en = 1'b0;
    b = '0;
    for (int i = 0; i < 8; i++) begin
      wq();
      scl_m = 1'b1; wq();
      b = {b[6:0], sda_bus};
      wq();
      scl_m = 1'b0; wq();
    end
    m_en = 1'b1; sda_m = ~master_ack; wq();
    scl_m = 1'b1; wq(); wq();
    scl_m = 1'b0; wq();
    m_en = 1'b0;
  endtask

  task automatic wr(input logic [7:0] b, input string req);
    logic a, o;
    send_byte(b, a, o);
    chk(req, {31'd0, a}, 32'd0);
  endtask

  function automatic logic [3:0] ctl();
    return {div_stop, sleep_en, clk_out_en, fast_en};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic a, o;
    logic [7:0] rb;
    logic [7:0] exp_rd [7];

    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R1 reset state
    chk("R1 ctrl", {28'd0, ctl()}, 32'd0);
    chk("R1 sda_oe", {31'd0, sda_oe}, 32'd0);
    chk("R1 access", {31'd0, access_active}, 32'd0);
    chk("R1 ld_valid", {31'd0, ld_valid}, 32'd0);

    // R2/R3/R9 write address, R4/R6 instructions in mixed order
    m_start();
    send_byte(8'hA0, a, o);
    chk("R2 write addr ack", {31'd0, a}, 32'd0);
    chk("R3 ack drive enable", {31'd0, o}, 32'd1);
    chk("R9 access rises", {31'd0, access_active}, 32'd1);
    send_byte(8'h11, a, o);
    chk("R3 data ack", {30'd0, a, o}, 32'd1);
    chk("R4 div stop on", {28'd0, ctl()}, 32'b1000);
    wr(8'h31, "R3 ack");
    chk("R4 clk out on", {28'd0, ctl()}, 32'b1010);
    wr(8'h41, "R3 ack");
    chk("R4 fast on", {28'd0, ctl()}, 32'b1011);
    wr(8'h21, "R3 ack");
    chk("R6 sleep on", {28'd0, ctl()}, 32'b1111);
    wr(8'h55, "R3 ack");
    chk("R4 unknown byte no effect", {28'd0, ctl()}, 32'b1111);
    wr(8'h30, "R3 ack");
    wr(8'h20, "R3 ack");
    chk("R6 clear in other order", {28'd0, ctl()}, 32'b1001);
    m_stop();
    chk("R9 access falls at stop", {31'd0, access_active}, 32'd0);

    // R5 full load, then a fourth byte as instruction
    m_start();
    wr(8'hA0, "R2 ack");
    wr(8'h80, "R5 ack");
    exp_q.push_back({3'b100, 8'hAA}); wr(8'hAA, "R5 ack");
    exp_q.push_back({3'b010, 8'h55}); wr(8'h55, "R5 ack");
    exp_q.push_back({3'b001, 8'h0F}); wr(8'h0F, "R5 ack");
    wr(8'h40, "R5 ack");
    chk("R5 fourth byte is instruction", {28'd0, ctl()}, 32'b1000);
    m_stop();
    chk("R5 all beats seen", exp_q.size(), 32'd0);

    // R5 partial load cut by STOP
    m_start();
    wr(8'hA0, "R2 ack");
    wr(8'h80, "R5 ack");
    exp_q.push_back({3'b100, 8'h12}); wr(8'h12, "R5 ack");
    m_stop();
    m_start();
    wr(8'hA0, "R2 ack");
    wr(8'h10, "R5 ack");
    chk("R5 sequence cleared, byte decoded", {28'd0, ctl()}, 32'b0000);
    m_stop();
    chk("R5 partial beats only", exp_q.size(), 32'd0);

    // R7 cyclic read, R8 release after NACK
    cnt_value = 24'hA90001;
    exp_rd = '{8'hA9, 8'h00, 8'h01, 8'hA9, 8'h00, 8'h01, 8'hA9};
    m_start();
    send_byte(8'hA1, a, o);
    chk("R2 read addr ack", {31'd0, a}, 32'd0);
    for (int k = 0; k < 7; k++) begin
      recv_byte(k != 6, rb);
      chk($sformatf("R7 read byte %0d", k), {24'd0, rb}, {24'd0, exp_rd[k]});
    end
    for (int k = 0; k < 2; k++) begin
      wq(); scl_m = 1'b1; wq();
      chk("R8 released after nack", {31'd0, sda_oe}, 32'd0);
      wq(); scl_m = 1'b0; wq();
    end
    m_stop();
    chk("R9 access falls after read", {31'd0, access_active}, 32'd0);

    // R9 repeated START closes the access
    m_start();
    wr(8'hA0, "R2 ack");
    chk("R9 access open", {31'd0, access_active}, 32'd1);
    m_start();
    chk("R9 access falls at repeated start", {31'd0, access_active}, 32'd0);
    send_byte(8'hA1, a, o);
    chk("R2 read after repeated start", {31'd0, a}, 32'd0);
    recv_byte(1'b0, rb);
    chk("R7 single byte read", {24'd0, rb}, 32'hA9);
    m_stop();

    // R2 wrong address ignored until next STOP
    m_start();
    send_byte(8'h42, a, o);
    chk("R2 foreign addr no ack", {31'd0, a}, 32'd1);
    chk("R2 foreign addr no access", {31'd0, access_active}, 32'd0);
    send_byte(8'h11, a, o);
    chk("R2 ignored byte no ack", {31'd0, a}, 32'd1);
    chk("R2 ignored byte no effect", {28'd0, ctl()}, 32'd0);
    m_stop();
    m_start();
    wr(8'hA0, "R2 addr after ignore");
    m_stop();

    repeat (20) @(negedge clk);
    chk("R10 drive on with SCL low", drive_viol, 32'd0);
    chk("R5 queue empty", exp_q.size(), 32'd0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule